// File: doc/BRIEF.md
# Cell Greeting Match-and-Rewrite Stage

This block sits in a 32-bit cell stream. Each cell is 14 words long, and a start-of-cell flag marks its first word. The block checks whether a cell belongs to one chosen virtual circuit and whether its payload opens with the ASCII text "HELLO". When both are true, it writes " WORLD." into the payload straight after that text. The output payload then reads "HELLO WORLD." and the rest of the cell is untouched. Every other word passes through unchanged.

Inputs are captured in an edge register and outputs leave from a second edge register. Data, the start flag and the flow-control bit therefore all come out exactly two cycles after they go in. The match decision and the rewrite take place between the two registers, so cells can follow each other with no idle words and nothing stalls.

Word layout inside a cell:
- Word 0 is the cell header. It carries the circuit number in bits [19:4].
- Word 1 is a check/pad word.
- Words 2 to 13 carry the 48 payload bytes, big-endian, with byte 0 of each word in bits [31:24].

Top module: `cell_hello_rewrite`

## Requirements
- R1: When no rewrite applies, data_o and soc_o equal data_i and soc_i from exactly two clock cycles earlier.
- R2: A cell is a candidate only when header bits [19:4] equal VCI_MATCH (default 5). Cells with any other value leave the block unchanged. The header word itself is never altered.
- R3: A match needs payload word 2 to equal 32'h48454C4C ("HELL") and bits [31:24] of word 3 to equal 8'h4F ("O"). If either test fails, the cell is forwarded unmodified.
- R4: On a match, word 3 keeps bits [31:24] and its bits [23:0] become 24'h20574F (" WO"). Word 4 becomes 32'h524C442E ("RLD."). Every other word of the cell is unchanged.
- R5: Cells that arrive back to back, each 14 words with soc_i on word 0, are all parsed and rewritten with no lost or stalled word.
- R6: A soc_i that arrives before word 13 ends the current cell and restarts parsing at word 0. Words of the cut-off cell that have not yet been emitted are not rewritten.
- R7: Words that arrive outside a cell (after word 13 and before the next soc_i) pass unchanged, even when they hold the pattern.
- R8: flow_o equals flow_i from exactly two cycles earlier, whatever the data.
- R9: While rst_ni is low, data_o, soc_o and flow_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Incoming cell word |
| soc_i | input | 1 | Incoming start-of-cell flag |
| flow_i | input | 1 | Incoming flow-control bit |
| data_o | output | 32 | Outgoing cell word, rewritten where matched |
| soc_o | output | 1 | Start-of-cell flag, delayed two cycles |
| flow_o | output | 1 | Flow-control bit, delayed two cycles |

## Verification
The bench builds the block with its defaults: VCI_MATCH = 5, a 14-word cell, and the circuit field at bits [19:4] with a width of 16. Single-bit neighbours of circuit 5 can therefore be tried against the exact-compare logic. The 14-word cell makes the counter wrap at a limit that is not a power of two, so both the end-of-cell stop and idle words after the cell are exercised. Because the rewrite sits at fixed word positions 3 and 4, cells cut short just before, at and after those words are in reach. This covers both an abort after a partial rewrite and a stale match leaking into the next cell.

// File: rtl/cell_rw_pkg.sv
package cell_rw_pkg;
  localparam int unsigned WORD_W = 32;

  // fixed word positions inside a cell
  localparam int unsigned HDR_IDX   = 0;
  localparam int unsigned PAT_IDX   = 2;
  localparam int unsigned SPLIT_IDX = 3;
  localparam int unsigned TAIL_IDX  = 4;

  localparam logic [31:0] PAT_WORD  = 32'h48454C4C; // "HELL"
  localparam logic [7:0]  PAT_LAST  = 8'h4F;        // "O"
  localparam logic [23:0] SPLIT_NEW = 24'h20574F;   // " WO"
  localparam logic [31:0] TAIL_WORD = 32'h524C442E; // "RLD."

  typedef struct packed {
    logic              flow;
    logic              soc;
    logic [WORD_W-1:0] data;
  } cell_beat_t;

  localparam int unsigned BEAT_W = $bits(cell_beat_t);
endpackage

// File: rtl/cell_rw_stage.sv
module cell_rw_stage #(
  parameter int unsigned W = 34
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cell_rw_tracker.sv
module cell_rw_tracker #(
  parameter int unsigned CELL_WORDS = 14,
  localparam int unsigned CNT_W = $clog2(CELL_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soc_i,
  output logic             active_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_WORDS - 1);

  logic             in_cell_q;
  logic [CNT_W-1:0] cnt_q;

  assign active_o = soc_i | in_cell_q;
  assign idx_o    = soc_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cell_q <= 1'b0;
      cnt_q     <= '0;
    end else if (soc_i) begin
      // start-of-cell always restarts, also mid-cell
      in_cell_q <= 1'b1;
      cnt_q     <= CNT_W'(1);
    end else if (in_cell_q) begin
      if (cnt_q == LAST) begin
        in_cell_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cell_rw_match.sv
module cell_rw_match
  import cell_rw_pkg::*;
#(
  parameter int unsigned CELL_WORDS = 14,
  parameter int unsigned VCI_LSB    = 4,
  parameter int unsigned VCI_W      = 16,
  parameter logic [VCI_W-1:0] VCI_MATCH = 16'd5,
  localparam int unsigned CNT_W = $clog2(CELL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic vci_hit_q, pat_hit_q, rw_hit_q;
  logic at_hdr, at_pat, at_split, at_tail;
  logic split_hit;

  assign at_hdr   = active_i && (idx_i == CNT_W'(HDR_IDX));
  assign at_pat   = active_i && (idx_i == CNT_W'(PAT_IDX));
  assign at_split = active_i && (idx_i == CNT_W'(SPLIT_IDX));
  assign at_tail  = active_i && (idx_i == CNT_W'(TAIL_IDX));

  assign split_hit = at_split && vci_hit_q && pat_hit_q &&
                     (word_i[WORD_W-1 -: 8] == PAT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vci_hit_q <= 1'b0;
      pat_hit_q <= 1'b0;
      rw_hit_q  <= 1'b0;
    end else if (at_hdr) begin
      vci_hit_q <= (word_i[VCI_LSB +: VCI_W] == VCI_MATCH);
      pat_hit_q <= 1'b0;
      rw_hit_q  <= 1'b0;
    end else begin
      if (at_pat)   pat_hit_q <= (word_i == PAT_WORD);
      if (at_split) rw_hit_q  <= split_hit;
    end
  end

  always_comb begin
    word_o = word_i;
    if (split_hit)             word_o = {word_i[WORD_W-1 -: 8], SPLIT_NEW};
    else if (at_tail && rw_hit_q) word_o = TAIL_WORD;
  end
endmodule

// File: rtl/cell_hello_rewrite.sv
module cell_hello_rewrite
  import cell_rw_pkg::*;
#(
  parameter int unsigned CELL_WORDS = 14,
  parameter int unsigned VCI_LSB    = 4,
  parameter int unsigned VCI_W      = 16,
  parameter logic [VCI_W-1:0] VCI_MATCH = 16'd5,
  localparam int unsigned CNT_W = $clog2(CELL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              soc_i,
  input  logic              flow_i,
  output logic [WORD_W-1:0] data_o,
  output logic              soc_o,
  output logic              flow_o
);
  cell_beat_t in_q, mid_d, out_q;
  logic             active;
  logic [CNT_W-1:0] idx;
  logic [WORD_W-1:0] new_word;

  cell_rw_stage #(.W(BEAT_W)) u_in (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({flow_i, soc_i, data_i}),
    .q_o   (in_q)
  );

  cell_rw_tracker #(.CELL_WORDS(CELL_WORDS)) u_trk (
    .clk_i   (clk_i), .rst_ni(rst_ni),
    .soc_i   (in_q.soc),
    .active_o(active),
    .idx_o   (idx)
  );

  cell_rw_match #(
    .CELL_WORDS(CELL_WORDS), .VCI_LSB(VCI_LSB),
    .VCI_W(VCI_W), .VCI_MATCH(VCI_MATCH)
  ) u_match (
    .clk_i   (clk_i), .rst_ni(rst_ni),
    .active_i(active),
    .idx_i   (idx),
    .word_i  (in_q.data),
    .word_o  (new_word)
  );

  always_comb begin
    mid_d      = in_q;
    mid_d.data = new_word;
  end

  cell_rw_stage #(.W(BEAT_W)) u_out (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   (mid_d),
    .q_o   (out_q)
  );

  assign data_o = out_q.data;
  assign soc_o  = out_q.soc;
  assign flow_o = out_q.flow;
endmodule

// File: rtl/cell_hello_rewrite_chk.sv
module cell_hello_rewrite_chk
  import cell_rw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] data_i,
  input logic              soc_i,
  input logic              flow_i,
  input logic [WORD_W-1:0] data_o,
  input logic              soc_o,
  input logic              flow_o
);
  logic [WORD_W-1:0] d1_q, d2_q;
  logic s1_q, s2_q, f1_q, f2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= '0; d2_q <= '0;
      s1_q <= 1'b0; s2_q <= 1'b0;
      f1_q <= 1'b0; f2_q <= 1'b0;
    end else begin
      d1_q <= data_i; d2_q <= d1_q;
      s1_q <= soc_i;  s2_q <= s1_q;
      f1_q <= flow_i; f2_q <= f1_q;
    end
  end

  AST_SOC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_o == s2_q); // R1
  AST_FLOW_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flow_o == f2_q); // R8
  AST_HEADER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q |-> data_o == d2_q); // R2
  AST_REWRITE_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != d2_q) |-> ((data_o == TAIL_WORD) ||
                          (data_o == {PAT_LAST, SPLIT_NEW}))); // R4
  AST_SPLIT_TOP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != d2_q && data_o != TAIL_WORD) |->
      data_o[WORD_W-1 -: 8] == d2_q[WORD_W-1 -: 8]); // R4
endmodule

bind cell_hello_rewrite cell_hello_rewrite_chk u_chk (
  .clk_i (clk_i), .rst_ni(rst_ni),
  .data_i(data_i), .soc_i(soc_i), .flow_i(flow_i),
  .data_o(data_o), .soc_o(soc_o), .flow_o(flow_o)
);

// File: tb/tb_cell_hello_rewrite.sv
module tb_cell_hello_rewrite;
  localparam logic [31:0] HELL = 32'h48454C4C;
  localparam logic [31:0] TAIL = 32'h524C442E;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic        soc_i = 1'b0, flow_i = 1'b0;
  logic [31:0] data_o;
  logic        soc_o, flow_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] r_d [4];
  logic        r_s [4];
  logic        r_f [4];
  string       r_t [4];
  bit          r_v [4];

  logic [31:0] cw [14];
  logic [31:0] ce [14];

  always #2.5 clk = ~clk;

  cell_hello_rewrite dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .data_i(data_i), .soc_i(soc_i), .flow_i(flow_i),
    .data_o(data_o), .soc_o(soc_o), .flow_o(flow_o)
  );

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference: rewrite rule applied to a full cell image
  function automatic void build_expected();
    bit hit;
    for (int i = 0; i < 14; i++) ce[i] = cw[i];
    hit = (cw[0][19:4] == 16'd5) && (cw[2] == HELL) && (cw[3][31:24] == 8'h4F);
    if (hit) begin
      ce[3] = {cw[3][31:24], 24'h20574F};
      ce[4] = TAIL;
    end
  endfunction

  task automatic step(logic [31:0] d, logic s, logic f, logic [31:0] e, string tag);
    int k;
    @(negedge clk);
    k = (cyc + 2) % 4;
    if (r_v[k]) begin
      chk32(r_t[k], data_o, r_d[k]);
      chk32(r_s[k] ? "R5 soc" : "R1 soc", {31'd0, soc_o}, {31'd0, r_s[k]});
      chk32("R8 flow", {31'd0, flow_o}, {31'd0, r_f[k]});
    end
    k = cyc % 4;
    data_i = d; soc_i = s; flow_i = f;
    r_d[k] = e; r_s[k] = s; r_f[k] = f; r_v[k] = 1'b1;
    r_t[k] = (e !== d) ? "R4 data" : tag;
    cyc++;
  endtask

  task automatic send_cell(int len, string tag);
    build_expected();
    for (int i = 0; i < len; i++)
      step(cw[i], i == 0, 1'($urandom % 2), ce[i], tag);
  endtask

  task automatic idle(int n, bit use_pat);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = use_pat ? HELL : $urandom;
      step(w, 1'b0, 1'($urandom % 2), w, "R7 idle");
    end
  endtask

  task automatic make_cell(logic [15:0] vci, logic [31:0] w2, logic [7:0] b3);
    for (int i = 0; i < 14; i++) cw[i] = $urandom;
    cw[0][19:4] = vci;
    cw[2] = w2;
    cw[3][31:24] = b3;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4; i++) r_v[i] = 1'b0;
    data_i = 32'hFFFF_FFFF; soc_i = 1'b1; flow_i = 1'b1;
    repeat (3) @(negedge clk);
    chk32("R9 reset data", data_o, 32'h0);
    chk32("R9 reset soc",  {31'd0, soc_o}, 32'h0);
    chk32("R9 reset flow", {31'd0, flow_o}, 32'h0);
    data_i = '0; soc_i = 1'b0; flow_i = 1'b0;
    rst_ni = 1'b1;

    // pattern outside any cell
    idle(3, 1'b1);                                   // R7
    // exact greeting cell
    make_cell(16'd5, HELL, 8'h4F);
    cw[3] = 32'h4F454545;
    send_cell(14, "R4 greet");
    // back-to-back matching cells
    for (int n = 0; n < 3; n++) begin
      make_cell(16'd5, HELL, 8'h4F);
      send_cell(14, "R5 b2b");
    end
    // circuit field mismatches
    make_cell(16'd4, HELL, 8'h4F);  send_cell(14, "R2 vci");
    make_cell(16'd0, HELL, 8'h4F);  cw[0][3:0] = 4'd5; send_cell(14, "R2 vci pos");
    make_cell(16'h8005, HELL, 8'h4F); send_cell(14, "R2 vci hi");
    // pattern mismatches
    make_cell(16'd5, 32'h48454C4D, 8'h4F); send_cell(14, "R3 hell");
    make_cell(16'd5, HELL, 8'h6F);          send_cell(14, "R3 o");
    idle(2, 1'b0);
    // abort before word 3, then full match
    make_cell(16'd5, HELL, 8'h4F); send_cell(3, "R6 abort2");
    make_cell(16'd5, HELL, 8'h4F); send_cell(14, "R6 next");
    // abort after word 3 rewrite; next cell must not inherit the match
    make_cell(16'd5, HELL, 8'h4F); send_cell(4, "R6 abort3");
    make_cell(16'd5, HELL, 8'h58); send_cell(14, "R6 stale");
    idle(1, 1'b1);

    // constrained random cells
    for (int n = 0; n < 300; n++) begin
      logic [15:0] v;
      logic [31:0] w2;
      logic [7:0]  b3;
      int len, gap;
      string tag;
      case ($urandom % 4)
        0, 1: v = 16'd5;
        2:    v = 16'($urandom);
        default: v = 16'd5 ^ (16'd1 << ($urandom % 16));
      endcase
      w2 = ($urandom % 3 != 0) ? HELL : (HELL ^ (32'd1 << ($urandom % 32)));
      b3 = ($urandom % 3 != 0) ? 8'h4F : 8'($urandom);
      make_cell(v, w2, b3);
      len = ($urandom % 10 == 0) ? 1 + int'($urandom % 13) : 14;
      if (len < 14) tag = "R6 rnd";
      else if (v != 16'd5) tag = "R2 rnd";
      else if (w2 != HELL || b3 != 8'h4F) tag = "R3 rnd";
      else tag = "R1 rnd";
      send_cell(len, tag);
      gap = (len < 14 || $urandom % 2 == 0) ? 0 : 1 + int'($urandom % 3);
      if (gap > 0) idle(gap, 1'($urandom % 2));
    end
    idle(3, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule